// File: doc/BRIEF.md
# Firmware Sleep/Wake Mailbox

This block is the target side of a small mailbox that lets a host ask an embedded management microcontroller to go quiet before a long bus transfer and to resume afterwards. The host sees two byte-wide I/O ports. A write to the index port picks a mailbox register. The data port then reads or writes the register that was picked. The mailbox registers are a small array placed at a base index.

To issue a request, the host first clears the status register and writes a command byte. It then writes a fixed key value into the doorbell register. The doorbell starts a modelled agent. The agent takes a copy of the command when the doorbell rings and stays busy for a programmable number of clock cycles. When it finishes a sleep or wake command, it overwrites the status register with an acknowledge code and updates a sleep-state output. The host polls the status register until it sees the acknowledge code.

A platform enable input gates the whole feature. When the input is low, the doorbell does nothing.

Top module: `fw_sleep_mailbox`

## Requirements
- R1: After a synchronous reset, every mailbox register reads 0x00, the index register reads 0x00, and `agent_busy` and `sleep_state` are both 0.
- R2: A write at I/O address `INDEX_PORT` (default 0x3E) loads the index register on that clock edge. A read at `INDEX_PORT` returns the index register.
- R3: A write at `DATA_PORT` (default 0x3F) stores the byte into the mailbox register selected by the index, when that index lies in `BASE` to `BASE+DEPTH-1` (default 0x80 to 0x8F). A read at `DATA_PORT` returns that register. For an index outside the range, writes are dropped and reads return 0x00. Writes to any other I/O address change nothing.
- R4: A data-port write of 0x96 to index 0x80 (the doorbell) sets `agent_busy` on the next clock edge, provided `agent_en` is 1 and the agent is idle. With `agent_en` at 0, or with any other value written, `agent_busy` stays 0.
- R5: `agent_busy` stays 1 for exactly `LATENCY` clock cycles after the doorbell edge. On the edge where it falls, a valid command writes the acknowledge code 0xFA into status register 0x82.
- R6: Command byte 0xB4 in register 0x83 is a sleep request. When it completes, `sleep_state` goes to 1. Command byte 0xB5 is a wake request. When it completes, `sleep_state` goes to 0.
- R7: Any other command byte still runs the full busy period. It leaves register 0x82 and `sleep_state` unchanged.
- R8: A doorbell that arrives while the agent is busy is ignored. Completion still happens `LATENCY` cycles after the first doorbell.
- R9: The command is taken from register 0x83 on the doorbell edge. Rewriting 0x83 while the agent is busy does not change the result of the pending command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| agent_en | input | 1 | Platform enable for the feature (configuration bit 7) |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | IO_AW | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data; combinational from io_addr and the index |
| agent_busy | output | 1 | A command is pending in the agent |
| sleep_state | output | 1 | The microcontroller is in the sleep state |

## Verification
The doorbell is tried with several inputs, and each one separates a different kind of fault:
- The feature disabled, which shows that the enable gates the start.
- A wrong key value, which shows that the key is compared in full.
- A valid sleep command, which is sampled one cycle before and one cycle after the expected completion edge to pin the latency.
- An unknown command, which shows that acknowledge and state change depend on decoding the command.
- A second doorbell while busy, which would move the completion edge if it restarted the timer.
- A command rewritten during the busy period, which tells a command captured at the doorbell apart from one read live at completion.

The register path is checked with in-range, out-of-range and foreign-address writes.

// File: rtl/fw_mbx_pkg.sv
package fw_mbx_pkg;

    localparam logic [7:0] DOORBELL_KEY = 8'h96;
    localparam logic [7:0] CMD_SLEEP    = 8'hB4;
    localparam logic [7:0] CMD_WAKE     = 8'hB5;
    localparam logic [7:0] ACK_CODE     = 8'hFA;

    // register offsets from the mailbox base index
    localparam int OFS_DOORBELL = 0;
    localparam int OFS_STATUS   = 2;
    localparam int OFS_CMD      = 3;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'd0,
        REQ_SLEEP = 2'd1,
        REQ_WAKE  = 2'd2
    } req_e;

    typedef struct packed {
        logic       en;
        logic [7:0] ofs;
        logic [7:0] data;
    } host_wr_t;

    function automatic req_e decode_cmd(input logic [7:0] cmd);
        if (cmd == CMD_SLEEP)     return REQ_SLEEP;
        else if (cmd == CMD_WAKE) return REQ_WAKE;
        else                      return REQ_NONE;
    endfunction

endpackage

// File: rtl/fw_mbx_decode.sv
module fw_mbx_decode
    import fw_mbx_pkg::*;
#(
    parameter int             IO_AW      = 16,
    parameter logic [IO_AW-1:0] INDEX_PORT = 16'h003E,
    parameter logic [IO_AW-1:0] DATA_PORT  = 16'h003F,
    parameter logic [7:0]     BASE       = 8'h80,
    parameter int             DEPTH      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       index_q,
    output logic             sel_index,
    output logic             sel_data,
    output logic             in_range,
    output logic [7:0]       ofs,
    output host_wr_t         hw
);

    localparam logic [8:0] LIMIT = {1'b0, BASE} + 9'(DEPTH);

    assign sel_index = (io_addr == INDEX_PORT);
    assign sel_data  = (io_addr == DATA_PORT);
    assign in_range  = (index_q >= BASE) && ({1'b0, index_q} < LIMIT);
    assign ofs       = index_q - BASE;

    always_ff @(posedge clk) begin
        if (rst)                     index_q <= '0;
        else if (io_wr && sel_index) index_q <= io_wdata;
    end

    always_comb begin
        hw.en   = io_wr && sel_data && in_range;
        hw.ofs  = ofs;
        hw.data = io_wdata;
    end

    assert_index_load_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == INDEX_PORT) |=> (index_q == $past(io_wdata)));

endmodule

// File: rtl/fw_mbx_regfile.sv
module fw_mbx_regfile
    import fw_mbx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  host_wr_t   hw,
    input  logic       ack_we,
    input  logic [7:0] rd_ofs,
    output logic [7:0] rd_data,
    output logic [7:0] cmd_byte
);

    logic [DEPTH-1:0][7:0] mem;

    // host writes first; agent acknowledge overrides the status entry
    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (hw.en && hw.ofs == 8'(i)) mem[i] <= hw.data;
            end
            if (ack_we) mem[OFS_STATUS] <= ACK_CODE;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ofs == 8'(i)) rd_data = mem[i];
        end
    end

    assign cmd_byte = mem[OFS_CMD];

    assert_ack_written_R5: assert property (@(posedge clk) disable iff (rst)
        ack_we |=> (mem[OFS_STATUS] == ACK_CODE));

    assert_status_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!ack_we && !(hw.en && hw.ofs == 8'(OFS_STATUS))) |=> $stable(mem[OFS_STATUS]));

endmodule

// File: rtl/fw_mbx_agent.sv
module fw_mbx_agent
    import fw_mbx_pkg::*;
#(
    parameter int LATENCY = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  host_wr_t   hw,
    input  logic [7:0] cmd_byte,
    output logic       busy,
    output logic       sleep_state,
    output logic       ack_we
);

    localparam int CNTW = $clog2(LATENCY + 1);

    logic            busy_q;
    logic            sleep_q;
    logic [CNTW-1:0] cnt_q;
    req_e            req_q;
    logic            ring;
    logic            done;

    assign ring = enable && !busy_q && hw.en
               && hw.ofs == 8'(OFS_DOORBELL) && hw.data == DOORBELL_KEY;
    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            sleep_q <= 1'b0;
            cnt_q   <= '0;
            req_q   <= REQ_NONE;
        end else if (ring) begin
            busy_q <= 1'b1;
            cnt_q  <= CNTW'(LATENCY - 1);
            req_q  <= decode_cmd(cmd_byte);
        end else if (done) begin
            busy_q <= 1'b0;
            if (req_q == REQ_SLEEP)     sleep_q <= 1'b1;
            else if (req_q == REQ_WAKE) sleep_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy        = busy_q;
    assign sleep_state = sleep_q;
    assign ack_we      = done && (req_q != REQ_NONE);

    assert_busy_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

    assert_sleep_moves_on_done_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sleep_q) |-> $past(done));

endmodule

// File: rtl/fw_sleep_mailbox.sv
module fw_sleep_mailbox
    import fw_mbx_pkg::*;
#(
    parameter int               IO_AW      = 16,
    parameter logic [IO_AW-1:0] INDEX_PORT = 16'h003E,
    parameter logic [IO_AW-1:0] DATA_PORT  = 16'h003F,
    parameter logic [7:0]       BASE       = 8'h80,
    parameter int               DEPTH      = 16,
    parameter int               LATENCY    = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             agent_en,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             agent_busy,
    output logic             sleep_state
);

    logic [7:0] index_q;
    logic       sel_index;
    logic       sel_data;
    logic       in_range;
    logic [7:0] ofs;
    host_wr_t   hw;
    logic [7:0] rd_data;
    logic [7:0] cmd_byte;
    logic       ack_we;

    fw_mbx_decode #(
        .IO_AW(IO_AW), .INDEX_PORT(INDEX_PORT), .DATA_PORT(DATA_PORT),
        .BASE(BASE), .DEPTH(DEPTH)
    ) u_decode (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .index_q(index_q), .sel_index(sel_index),
        .sel_data(sel_data), .in_range(in_range), .ofs(ofs), .hw(hw)
    );

    fw_mbx_regfile #(.DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst(rst), .hw(hw), .ack_we(ack_we), .rd_ofs(ofs),
        .rd_data(rd_data), .cmd_byte(cmd_byte)
    );

    fw_mbx_agent #(.LATENCY(LATENCY)) u_agent (
        .clk(clk), .rst(rst), .enable(agent_en), .hw(hw),
        .cmd_byte(cmd_byte), .busy(agent_busy), .sleep_state(sleep_state),
        .ack_we(ack_we)
    );

    always_comb begin
        if (sel_index)                 io_rdata = index_q;
        else if (sel_data && in_range) io_rdata = rd_data;
        else                           io_rdata = '0;
    end

    assert_start_needs_doorbell_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(agent_busy) |-> $past(io_wr && io_addr == DATA_PORT && agent_en));

endmodule

// File: tb/tb_fw_sleep_mailbox.sv
module tb_fw_sleep_mailbox;

    localparam int           LAT   = 6;
    localparam logic [15:0]  IDX_P = 16'h003E;
    localparam logic [15:0]  DAT_P = 16'h003F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        agent_en = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = DAT_P;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        agent_busy;
    logic        sleep_state;

    always #4 clk = ~clk;

    fw_sleep_mailbox #(.LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .agent_en(agent_en), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .agent_busy(agent_busy), .sleep_state(sleep_state)
    );

    typedef struct {
        int         kind;   // 0 read data, 1 busy, 2 sleep state
        logic [7:0] exp;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       it;
    logic [7:0] act;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 0;

    // monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = io_rdata;
                1:       act = {7'd0, agent_busy};
                default: act = {7'd0, sleep_state};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_v(input int kind, input logic [7:0] e, input string tag);
        exp_t x;
        x.kind = kind; x.exp = e; x.tag = tag;
        sb_q.push_back(x);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(posedge clk); #1;
        io_wr = 1'b0; io_addr = DAT_P;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        io_write(IDX_P, idx);
        io_write(DAT_P, d);
    endtask

    task automatic reg_check(input logic [7:0] idx, input logic [7:0] e, input string tag);
        io_write(IDX_P, idx);
        expect_v(0, e, tag);
    endtask

    // after a doorbell edge: busy one cycle before completion, idle after
    task automatic check_completion(input int steps_left, input string tag);
        for (int k = 0; k < steps_left; k++) step();
        expect_v(1, 8'h01, {tag, " busy before last edge"});
        step();
        expect_v(1, 8'h00, {tag, " idle after latency"});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        io_addr = IDX_P;
        expect_v(0, 8'h00, "R1 index after reset");
        expect_v(1, 8'h00, "R1 busy after reset");
        expect_v(2, 8'h00, "R1 sleep after reset");
        step();
        io_addr = DAT_P;
        reg_check(8'h82, 8'h00, "R1 status reg after reset");

        // R2 index register readback
        io_write(IDX_P, 8'h83);
        io_addr = IDX_P;
        expect_v(0, 8'h83, "R2 index readback");
        step();
        io_addr = DAT_P;

        // R3 register access, range and foreign address
        reg_write(8'h83, 8'h5A);
        expect_v(0, 8'h5A, "R3 data readback");
        reg_write(8'h20, 8'h11);
        expect_v(0, 8'h00, "R3 out-of-range read is zero");
        io_write(16'h0070, 8'hEE);
        reg_check(8'h83, 8'h5A, "R3 foreign address write ignored");
        reg_check(8'h8F, 8'h00, "R3 top entry untouched");

        // R4 doorbell gating
        agent_en = 1'b0;
        reg_write(8'h80, 8'h96);
        expect_v(1, 8'h00, "R4 disabled doorbell ignored");
        agent_en = 1'b1;
        reg_write(8'h80, 8'h95);
        expect_v(1, 8'h00, "R4 wrong key ignored");

        // R5 R6 sleep command
        reg_write(8'h82, 8'h00);
        reg_write(8'h83, 8'hB4);
        reg_write(8'h80, 8'h96);
        expect_v(1, 8'h01, "R4 doorbell starts agent");
        check_completion(LAT - 1, "R5 sleep");
        expect_v(2, 8'h01, "R6 sleep state set");
        reg_check(8'h82, 8'hFA, "R5 acknowledge code");

        // R7 unknown command
        reg_write(8'h82, 8'h00);
        reg_write(8'h83, 8'h12);
        reg_write(8'h80, 8'h96);
        check_completion(LAT - 1, "R7 unknown cmd");
        expect_v(2, 8'h01, "R7 sleep unchanged");
        reg_check(8'h82, 8'h00, "R7 status unchanged");

        // R8 doorbell while busy
        reg_write(8'h82, 8'h00);
        reg_write(8'h83, 8'hB4);
        reg_write(8'h80, 8'h96);
        io_write(DAT_P, 8'h96);
        check_completion(LAT - 3, "R8 second doorbell");
        reg_check(8'h82, 8'hFA, "R8 acknowledge once");

        // R9 command captured at doorbell
        reg_write(8'h82, 8'h00);
        reg_write(8'h83, 8'hB5);
        reg_write(8'h80, 8'h96);
        reg_write(8'h83, 8'hB4);
        check_completion(LAT - 5, "R9 wake");
        expect_v(2, 8'h00, "R9 wake applied despite rewrite");
        reg_check(8'h83, 8'hB4, "R9 rewritten cmd stored");

        step();
        step();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule